// File: doc/BRIEF.md
# Time-of-Day Counter with Alarms

This block is a real-time clock core. A free-running reference enable (one pulse per reference oscillator period) is divided by a parameterised prescaler into a one-second advance. Each advance moves a seconds counter forward. Seconds carry into minutes, minutes into hours, and hours into a 16-bit day count. From the same reference pulses it derives three interrupt sources:

- A time-of-day match alarm.
- A fixed-rate sampling event.
- A stopwatch that counts down in whole minutes.

Software reaches every register through a single-cycle write strobe and a combinational read port. Each interrupt source has a sticky status bit and its own enable bit. One interrupt output collects them.

There is no data stream at this block's edge. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. A write is accepted on the clock edge where `wr_en` is high. `rdata` always reflects `addr` in the same cycle.

Top module: `tod_rtc_core`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The seconds counter advances once for every PRESCALE_DIV clock cycles in which `ref_en` is high. Cycles with `ref_en` low do not count.
- R3: Seconds and minutes wrap from 59 to 0 and carry upward. Hours wrap from 23 to 0 and carry into the day count. The day count is 16 bits and wraps from 65535 to 0.
- R4: A write to the seconds register (address 0) restarts the prescaler. The next advance comes only after a further PRESCALE_DIV `ref_en` pulses.
- R5: A write to any time register (addresses 0 seconds, 1 minutes, 2 hours, 3 days) takes effect at the next clock edge. An advance that falls on the same edge is dropped.
- R6: Status bit 0 (alarm) is set on an edge where all three conditions hold: the alarm is armed (bit 0 of address 7), the time advances, and the new seconds, minutes and hours equal the alarm values at addresses 4, 5 and 6. A write to a time register never sets it.
- R7: Status bit 1 (sampling) is set once every SAMPLE_DIV `ref_en` pulses. Time-register writes do not affect it.
- R8: Writing N to address 10 loads the stopwatch, which runs if N is non-zero. While running, it decrements on each minute rollover. On reaching zero it sets status bit 2 and stops. Writing 0 stops it. Reading address 10 returns the remaining count.
- R9: Status (address 8) bits are cleared by writing 1 to them. A set on the same edge wins over the clear. Interrupt enables live at address 9, bits 2:0. Unused bits of both registers read zero.
- R10: `irq` is high exactly when some status bit and its enable bit are both set.
- R11: Addresses 11 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One pulse per reference oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, zero-extended |
| irq | output | 1 | OR of the enabled status bits |

## Verification
The embedded assertions check the following on every cycle:

- Prescaler restarts and the spacing between one-second pulses.
- The seconds wrap and the day carry.
- Write precedence over an advance.
- A stopwatch that fires stops, and one that is idle holds its count.
- Set-over-clear priority of the status bits.
- The alarm bit rises only after an armed advance.

Only the bench's scenarios can show the following, by running a behavioural model in step with the design and reading every register in rotation:

- The absolute timing of advances under sparse reference pulses.
- The full midnight and day rollover.
- The sampling rate.
- The minute count of the stopwatch.
- That writing a matching time raises no alarm.

// File: rtl/tod_rtc_pkg.sv
package tod_rtc_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 16;
  localparam int SW_W   = 8;
  localparam int NSRC   = 3;

  localparam logic [ADDR_W-1:0] ADR_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DAY   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_ASEC  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_AMIN  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_AHOUR = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_SWCH  = 4'd10;

  localparam int S_ALARM  = 0;
  localparam int S_SAMPLE = 1;
  localparam int S_SWATCH = 2;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } hms_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic restart,
  output logic pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (ref_en)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign pulse = ref_en && !restart && (cnt_q == LAST);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  generate
    if (DIV > 1) begin : g_gap
      p_pulse_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    end
  endgenerate
endmodule

// File: rtl/tod_counters.sv
module tod_counters
  import tod_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_sec,
  input  logic              wr_min,
  input  logic              wr_hour,
  input  logic              wr_day,
  input  logic [REG_W-1:0]  wdata,
  output hms_t              now,
  output hms_t              nxt,
  output logic [DAY_W-1:0]  day,
  output logic              adv,
  output logic              min_roll
);
  localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(23);

  hms_t             cur_q;
  logic [DAY_W-1:0] day_q, day_nxt;
  logic             sec_top, min_top, hour_top, any_wr;

  assign any_wr   = wr_sec | wr_min | wr_hour | wr_day;
  assign adv      = tick && !any_wr;
  assign sec_top  = cur_q.sec  >= SEC_TOP;
  assign min_top  = cur_q.min  >= MIN_TOP;
  assign hour_top = cur_q.hour >= HOUR_TOP;

  always_comb begin
    nxt.sec  = sec_top ? '0 : cur_q.sec + 1'b1;
    nxt.min  = cur_q.min;
    nxt.hour = cur_q.hour;
    day_nxt  = day_q;
    if (sec_top) begin
      nxt.min = min_top ? '0 : cur_q.min + 1'b1;
      if (min_top) begin
        nxt.hour = hour_top ? '0 : cur_q.hour + 1'b1;
        if (hour_top) day_nxt = day_q + 1'b1;
      end
    end
  end

  assign min_roll = adv && sec_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      day_q <= '0;
    end else if (adv) begin
      cur_q <= nxt;
      day_q <= day_nxt;
    end else begin
      if (wr_sec)  cur_q.sec  <= wdata[SEC_W-1:0];
      if (wr_min)  cur_q.min  <= wdata[MIN_W-1:0];
      if (wr_hour) cur_q.hour <= wdata[HOUR_W-1:0];
      if (wr_day)  day_q      <= wdata[DAY_W-1:0];
    end
  end

  assign now = cur_q;
  assign day = day_q;

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_q.sec == SEC_TOP) |=> (cur_q.sec == '0));

  p_day_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_q.sec == SEC_TOP && cur_q.min == MIN_TOP && cur_q.hour == HOUR_TOP)
    |=> (day_q == DAY_W'($past(day_q) + 1'b1)) && (cur_q.hour == '0));

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_min |=> (cur_q.min == $past(wdata[MIN_W-1:0])));
endmodule

// File: rtl/tod_stopwatch.sv
module tod_stopwatch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign fire = step && run_q && !load && (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (step && run_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == W'(1)) run_q <= 1'b0;
    end
  end

  assign count = cnt_q;

  p_fire_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!run_q && cnt_q == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         ien_wr,
  input  logic [N-1:0] ien_val,
  output logic [N-1:0] stat,
  output logic [N-1:0] ien,
  output logic         irq
);
  logic [N-1:0] stat_q, ien_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= set[i] | (stat_q[i] & ~(clr_wr & clr_mask[i]));
      end

      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> stat_q[i]);

      p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[i] && !set[i]) |=> !stat_q[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= ien_val;
  end

  assign stat = stat_q;
  assign ien  = ien_q;
  assign irq  = |(stat_q & ien_q);
endmodule

// File: rtl/tod_rtc_core.sv
module tod_rtc_core
  import tod_rtc_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768,
  parameter int SAMPLE_DIV   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic             wr_sec, wr_min, wr_hour, wr_day, tod_wr;
  logic             sec_tick, samp_pulse, tod_adv, min_roll, sw_fire, alarm_hit;
  hms_t             now, nxt, alarm_q;
  logic [DAY_W-1:0] day;
  logic             arm_q;
  logic [SW_W-1:0]  sw_count;
  logic [NSRC-1:0]  src_set, src_stat, src_ien;

  assign wr_sec  = wr_en && (addr == ADR_SEC);
  assign wr_min  = wr_en && (addr == ADR_MIN);
  assign wr_hour = wr_en && (addr == ADR_HOUR);
  assign wr_day  = wr_en && (addr == ADR_DAY);
  assign tod_wr  = wr_sec | wr_min | wr_hour | wr_day;

  tod_prescaler #(.DIV(PRESCALE_DIV)) u_sec_div (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(wr_sec), .pulse(sec_tick)
  );

  tod_prescaler #(.DIV(SAMPLE_DIV)) u_samp_div (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(1'b0), .pulse(samp_pulse)
  );

  tod_counters u_tod (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_day(wr_day),
    .wdata(wdata), .now(now), .nxt(nxt), .day(day),
    .adv(tod_adv), .min_roll(min_roll)
  );

  tod_stopwatch #(.W(SW_W)) u_swatch (
    .clk(clk), .rst_n(rst_n), .load(wr_en && (addr == ADR_SWCH)),
    .load_val(wdata[SW_W-1:0]), .step(min_roll), .count(sw_count), .fire(sw_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      arm_q   <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADR_ASEC)  alarm_q.sec  <= wdata[SEC_W-1:0];
      if (addr == ADR_AMIN)  alarm_q.min  <= wdata[MIN_W-1:0];
      if (addr == ADR_AHOUR) alarm_q.hour <= wdata[HOUR_W-1:0];
      if (addr == ADR_CTRL)  arm_q        <= wdata[0];
    end
  end

  assign alarm_hit = tod_adv && arm_q && (nxt == alarm_q);

  always_comb begin
    src_set           = '0;
    src_set[S_ALARM]  = alarm_hit;
    src_set[S_SAMPLE] = samp_pulse;
    src_set[S_SWATCH] = sw_fire;
  end

  tod_irq_ctrl #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(src_set),
    .clr_wr(wr_en && (addr == ADR_STAT)), .clr_mask(wdata[NSRC-1:0]),
    .ien_wr(wr_en && (addr == ADR_IEN)), .ien_val(wdata[NSRC-1:0]),
    .stat(src_stat), .ien(src_ien), .irq(irq)
  );

  always_comb begin
    case (addr)
      ADR_SEC:   rdata = REG_W'(now.sec);
      ADR_MIN:   rdata = REG_W'(now.min);
      ADR_HOUR:  rdata = REG_W'(now.hour);
      ADR_DAY:   rdata = REG_W'(day);
      ADR_ASEC:  rdata = REG_W'(alarm_q.sec);
      ADR_AMIN:  rdata = REG_W'(alarm_q.min);
      ADR_AHOUR: rdata = REG_W'(alarm_q.hour);
      ADR_CTRL:  rdata = REG_W'(arm_q);
      ADR_STAT:  rdata = REG_W'(src_stat);
      ADR_IEN:   rdata = REG_W'(src_ien);
      ADR_SWCH:  rdata = REG_W'(sw_count);
      default:   rdata = '0;
    endcase
  end

  p_alarm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_stat[S_ALARM]) |-> $past(tod_adv && arm_q));

  p_tod_wr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_wr && !src_stat[S_ALARM]) |=> !src_stat[S_ALARM]);
endmodule

// File: tb/test_tod_rtc_core.sv
module test_tod_rtc_core;
  localparam int PDIV = 4;
  localparam int SDIV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int ref_mode = 0;   // 0 off, 1 always, 3 pseudo-random
  bit rotate = 1'b1;
  int rd_sel = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tod_rtc_core #(.PRESCALE_DIV(PDIV), .SAMPLE_DIV(SDIV)) i_tod_rtc_core (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  int m_pre, m_sp, m_sec, m_min, m_hr, m_day, m_as, m_am, m_ah, m_arm;
  int m_stat, m_ien, m_sw, m_swrun;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_pre = 0; m_sp = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
      m_as = 0; m_am = 0; m_ah = 0; m_arm = 0; m_stat = 0; m_ien = 0;
      m_sw = 0; m_swrun = 0;
    end else begin
      int ns, nm, nh, nd, set;
      bit sec_w, tod_w, tick, adv, roll, hit, fire, samp, sw_w;
      sec_w = wr_en && addr == 0;
      tod_w = wr_en && addr <= 3;
      sw_w  = wr_en && addr == 10;
      tick  = ref_en && !sec_w && m_pre == PDIV - 1;
      if (sec_w) m_pre = 0;
      else if (ref_en) m_pre = (m_pre + 1) % PDIV;
      samp = ref_en && m_sp == SDIV - 1;
      if (ref_en) m_sp = (m_sp + 1) % SDIV;
      adv = tick && !tod_w;
      ns = m_sec; nm = m_min; nh = m_hr; nd = m_day;
      roll = 0;
      if (adv) begin
        ns = m_sec + 1;
        if (ns == 60) begin
          ns = 0; roll = 1; nm = m_min + 1;
          if (nm == 60) begin
            nm = 0; nh = m_hr + 1;
            if (nh == 24) begin nh = 0; nd = (m_day + 1) % 65536; end
          end
        end
      end
      hit  = adv && m_arm != 0 && ns == m_as && nm == m_am && nh == m_ah;
      fire = !sw_w && roll && m_swrun != 0 && m_sw == 1;
      if (sw_w) begin m_sw = wdata[7:0]; m_swrun = (wdata[7:0] != 0); end
      else if (roll && m_swrun != 0) begin
        m_sw = m_sw - 1;
        if (m_sw == 0) m_swrun = 0;
      end
      set = (fire ? 4 : 0) | (samp ? 2 : 0) | (hit ? 1 : 0);
      if (wr_en && addr == 8) m_stat = m_stat & ~int'(wdata[2:0]);
      m_stat = m_stat | set;
      if (adv) begin m_sec = ns; m_min = nm; m_hr = nh; m_day = nd; end
      else if (wr_en) begin
        case (addr)
          0: m_sec = wdata[5:0];
          1: m_min = wdata[5:0];
          2: m_hr  = wdata[4:0];
          3: m_day = wdata;
          default: ;
        endcase
      end
      if (wr_en) begin
        case (addr)
          4: m_as  = wdata[5:0];
          5: m_am  = wdata[5:0];
          6: m_ah  = wdata[4:0];
          7: m_arm = wdata[0];
          9: m_ien = wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_sec;   1: return m_min;  2: return m_hr;  3: return m_day;
      4: return m_as;    5: return m_am;   6: return m_ah;  7: return m_arm;
      8: return m_stat;  9: return m_ien;  10: return m_sw;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a <= 3) return "R3";
    if (a <= 7) return "R6";
    if (a <= 9) return "R9";
    if (a == 10) return "R8";
    return "R11";
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk(tag_of(int'(addr)), int'(rdata), exp_rd(int'(addr)));
      chk("R10", int'(irq), ((m_stat & m_ien) != 0) ? 1 : 0);
    end
  end

  task automatic drive_ref();
    ref_en = (ref_mode == 1) || (ref_mode == 3 && $urandom_range(0, 2) != 0);
  endtask

  task automatic step();
    @(posedge clk); #1;
    wr_en = 1'b0;
    drive_ref();
    if (rotate) rd_sel = (rd_sel + 1) % 12;
    addr = 4'(rd_sel);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    drive_ref();
  endtask

  task automatic peek(int a, output int v);
    rotate = 1'b0; rd_sel = a;
    step();
    @(negedge clk);
    v = int'(rdata);
    rotate = 1'b1;
  endtask

  int v;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a <= 10; a++) begin peek(a, v); chk("R1", v, 0); end
    chk("R1", int'(irq), 0);

    // R2: one second per PDIV reference pulses
    ref_mode = 1; wr(0, 0); run(20);
    ref_mode = 0; peek(0, v); chk("R2", v, 5);
    run(10); ref_mode = 1; run(4);
    ref_mode = 0; peek(0, v); chk("R2", v, 6);

    // R3: full rollover at midnight with day wrap
    wr(2, 23); wr(1, 59); wr(3, 16'hFFFF); wr(0, 58);
    ref_mode = 1; run(8); ref_mode = 0;
    peek(0, v); chk("R3", v, 0);
    peek(1, v); chk("R3", v, 0);
    peek(2, v); chk("R3", v, 0);
    peek(3, v); chk("R3", v, 0);

    // R4: seconds write restarts the prescaler
    ref_mode = 1; run(2); wr(0, 10); run(3);
    ref_mode = 0; peek(0, v); chk("R4", v, 10);
    ref_mode = 1; run(1);
    ref_mode = 0; peek(0, v); chk("R4", v, 11);

    // R5: a write on the advance edge wins and the advance is dropped
    ref_mode = 1; run(3); wr(1, 7);
    ref_mode = 0; peek(0, v); chk("R5", v, 11);
    peek(1, v); chk("R5", v, 7);

    // R6: armed alarm match on advance
    wr(9, 7); wr(4, 13); wr(5, 7); wr(6, 0); wr(7, 1); wr(8, 7);
    ref_mode = 1; run(8); ref_mode = 0;
    peek(8, v); chk("R6", v & 1, 1);
    chk("R10", int'(irq), 1);
    wr(8, 7); wr(0, 13);
    peek(8, v); chk("R6", v & 1, 0);
    wr(7, 0); wr(0, 12);
    ref_mode = 1; run(4); ref_mode = 0;
    peek(0, v); chk("R6", v, 13);
    peek(8, v); chk("R6", v & 1, 0);

    // R7: sampling event rate
    wr(8, 7); run(20);
    peek(8, v); chk("R7", v & 2, 0);
    ref_mode = 1; run(SDIV); ref_mode = 0;
    peek(8, v); chk("R7", v & 2, 2);

    // R8: minute stopwatch
    wr(8, 7); wr(10, 2); wr(0, 58);
    ref_mode = 1; run(8); ref_mode = 0;
    peek(10, v); chk("R8", v, 1);
    peek(8, v); chk("R8", v & 4, 0);
    ref_mode = 1; run(60 * PDIV); ref_mode = 0;
    peek(10, v); chk("R8", v, 0);
    peek(8, v); chk("R8", v & 4, 4);
    wr(8, 7); ref_mode = 1; run(60 * PDIV); ref_mode = 0;
    peek(8, v); chk("R8", v & 4, 0);
    wr(10, 3); wr(10, 0); ref_mode = 1; run(60 * PDIV); ref_mode = 0;
    peek(10, v); chk("R8", v, 0);
    peek(8, v); chk("R8", v & 4, 0);

    // R9 / R11: enable width, write-one-to-clear, unused addresses
    wr(9, 16'hFFFF); peek(9, v); chk("R9", v, 7);
    wr(8, 16'hFFFF); peek(8, v); chk("R9", v, 0);
    peek(11, v); chk("R11", v, 0);
    peek(15, v); chk("R11", v, 0);

    // R10: interrupt follows enabled status
    ref_mode = 1; run(SDIV); ref_mode = 0;
    wr(9, 0); peek(8, v); chk("R10", int'(irq), 0);
    wr(9, 2); peek(8, v); chk("R10", int'(irq), 1);
    wr(9, 1); peek(8, v); chk("R10", int'(irq), 0);

    // mixed traffic against the model
    ref_mode = 3;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        int a, d;
        a = $urandom_range(0, 11);
        case (a)
          0, 1, 4, 5: d = $urandom_range(0, 59);
          2, 6:       d = $urandom_range(0, 23);
          10:         d = $urandom_range(0, 3);
          default:    d = $urandom_range(0, 65535);
        endcase
        wr(a, d);
      end else step();
    end
    step();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    done = 1'b1;
    compared++; mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule